// File: doc/BRIEF.md
# Associative Virtual-to-Real Address Mapper

This block sits between a CPU and memory and turns each 15-bit virtual address into a 16-bit real address. Every request also carries a privilege flag (user or system) and an access kind (read, write or execute). The top six address bits name one of 64 pages. The bottom nine bits are a word offset that passes through unchanged. A small fully associative bank of map entries is searched in parallel. An entry hits when its privilege flag and its page both match the request. A hit either yields the real address or, when the entry's permission bits refuse the access kind, a protection trap.

When no entry matches, the mapper refills one by itself. It adds the page number to the table base of the request's privilege and reads one 16-bit word through a simple memory read port. It installs that word in the entry chosen by a circulating victim marker, then repeats the lookup. The CPU loads two 16-bit table bases, one per privilege. Loading either base discards every cached entry. System-privilege requests to page 0 skip translation and land in block 0. While a request is being served, the request port reports not-ready.

Top module: `addr_mapper`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, mem_rd_en is 0, every entry is invalid (so the first translated request misses) and the victim marker selects entry 0.
- R2: The virtual page is req_vaddr[14:9] and the offset is req_vaddr[8:0]. A permitted translated access returns resp_paddr = {block[6:0], offset[8:0]}.
- R3: A hit needs both the entry's privilege flag and its page to equal the request's. The same page under the other privilege misses.
- R4: req_kind encodes 0 read, 1 write, 2 execute and 3 reserved. An access is permitted when the entry bit for its kind is 1: read is table bit 9, write is bit 8, execute is bit 7. Kind 3 is never permitted. A refused access gives resp_valid with resp_trap=1 and resp_paddr=0.
- R5: A miss issues exactly one read, at (req_sys ? system base : user base) + page modulo 2^16. Bits 6:0 of the returned word are the block and bits 9:7 are the permissions. Bits 15:10 are ignored, and the entry is tagged with the request's page and privilege.
- R6: ptr_wr_en with ptr_wr_sel=1 loads the system base and with ptr_wr_sel=0 loads the user base. Either write invalidates every entry.
- R7: Refills replace entries in circular order. Each load moves the victim marker to the following entry, wrapping from the last entry to entry 0. Base writes do not move the marker.
- R8: A system-privilege request to page 0 is never translated. It returns resp_paddr = {7'b0, offset} with no trap and no memory read, whatever the kind.
- R9: req_ready is 1 only when idle. A request is accepted on a clock edge with req_valid and req_ready both 1. resp_valid pulses for one cycle: one cycle after acceptance on a hit or bypass, and one cycle after read data returns on a miss. req_ready stays 0 from acceptance through that response cycle.
- R10: NUM_ENT sets the entry count, from 8 to 32 in steps of 4. NUM_ENT distinct pages of one privilege can be resident at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Mapper idle and able to accept |
| req_vaddr | input | 15 | Virtual address |
| req_sys | input | 1 | 1 system privilege, 0 user |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| resp_valid | output | 1 | Response pulse |
| resp_trap | output | 1 | Protection trap with the response |
| resp_paddr | output | 16 | Real address (0 on trap) |
| ptr_wr_en | input | 1 | Table base write strobe |
| ptr_wr_sel | input | 1 | 1 system base, 0 user base |
| ptr_wr_data | input | 16 | New table base |
| mem_rd_en | output | 1 | Table word read strobe |
| mem_rd_addr | output | 16 | Table word address |
| mem_rd_valid | input | 1 | Table read data present |
| mem_rd_data | input | 16 | Table word |

## Verification
A corrupted entry tag or a lost valid bit shows on the read port at the very next request to that page: a read appears where none is due, or is missing where one is due. The response latency also grows from one cycle to four. A wrong victim marker stays hidden until the bank is full. It then shows one request after the first eviction, when a page that should still be resident misses. A wrong block or permission field shows in resp_paddr or resp_trap in the response cycle of the affected request. The bench tracks residency and the victim marker arithmetically and checks read count, read address, latency and result on every request.

// File: rtl/addr_mapper.sv
module addr_mapper #(
  parameter int NUM_ENT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [14:0] req_vaddr,
  input  logic        req_sys,
  input  logic [1:0]  req_kind,
  output logic        resp_valid,
  output logic        resp_trap,
  output logic [15:0] resp_paddr,
  input  logic        ptr_wr_en,
  input  logic        ptr_wr_sel,
  input  logic [15:0] ptr_wr_data,
  output logic        mem_rd_en,
  output logic [15:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [15:0] mem_rd_data
);
  localparam int PG_W  = 6;
  localparam int OFF_W = 9;
  localparam int BLK_W = 7;

  if (NUM_ENT < 8 || NUM_ENT > 32 || NUM_ENT % 4 != 0) begin : g_bad_cfg
    $error("NUM_ENT must be 8..32 in steps of 4");
  end

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_ISSUE, S_WAIT} st_t;

  st_t              st_q;
  logic [PG_W-1:0]  vpage_q;
  logic [OFF_W-1:0] off_q;
  logic             sys_q;
  logic [1:0]       kind_q;
  logic [15:0]      ptr_sys_q, ptr_usr_q;

  logic [NUM_ENT-1:0] ent_vld_q, ent_sys_q, next_q;
  logic [PG_W-1:0]    ent_page_q [NUM_ENT];
  logic [2:0]         ent_perm_q [NUM_ENT];
  logic [BLK_W-1:0]   ent_blk_q  [NUM_ENT];

  logic [NUM_ENT-1:0] hit_vec;
  logic [2:0]         hit_perm;
  logic [BLK_W-1:0]   hit_blk;
  logic               hit, bypass, allowed, load;

  always_comb begin
    hit_vec  = '0;
    hit_perm = '0;
    hit_blk  = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      hit_vec[i] = ent_vld_q[i] && (ent_sys_q[i] == sys_q) && (ent_page_q[i] == vpage_q);
      if (hit_vec[i]) begin
        hit_perm = hit_perm | ent_perm_q[i];
        hit_blk  = hit_blk | ent_blk_q[i];
      end
    end
  end

  always_comb begin
    case (kind_q)
      2'd0:    allowed = hit_perm[2];
      2'd1:    allowed = hit_perm[1];
      2'd2:    allowed = hit_perm[0];
      default: allowed = 1'b0;
    endcase
  end

  assign hit         = |hit_vec;
  assign bypass      = sys_q && (vpage_q == '0);
  assign req_ready   = (st_q == S_IDLE);
  assign resp_valid  = (st_q == S_LOOK) && (bypass || hit);
  assign resp_trap   = resp_valid && !bypass && !allowed;
  assign resp_paddr  = (resp_valid && !resp_trap) ?
                       {(bypass ? {BLK_W{1'b0}} : hit_blk), off_q} : 16'd0;
  assign mem_rd_en   = (st_q == S_ISSUE);
  assign mem_rd_addr = (sys_q ? ptr_sys_q : ptr_usr_q) + 16'(vpage_q);
  assign load        = (st_q == S_WAIT) && mem_rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      vpage_q <= '0;
      off_q   <= '0;
      sys_q   <= 1'b0;
      kind_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          st_q    <= S_LOOK;
          vpage_q <= req_vaddr[14:9];
          off_q   <= req_vaddr[8:0];
          sys_q   <= req_sys;
          kind_q  <= req_kind;
        end
        S_LOOK:  st_q <= (bypass || hit) ? S_IDLE : S_ISSUE;
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT:  if (mem_rd_valid) st_q <= S_LOOK;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_sys_q <= '0;
      ptr_usr_q <= '0;
    end else if (ptr_wr_en) begin
      if (ptr_wr_sel) ptr_sys_q <= ptr_wr_data;
      else            ptr_usr_q <= ptr_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld_q <= '0;
      next_q    <= NUM_ENT'(1);
    end else begin
      if (ptr_wr_en)  ent_vld_q <= '0;
      else if (load)  ent_vld_q <= ent_vld_q | next_q;
      if (load)       next_q <= {next_q[NUM_ENT-2:0], next_q[NUM_ENT-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_sys_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        ent_page_q[i] <= '0;
        ent_perm_q[i] <= '0;
        ent_blk_q[i]  <= '0;
      end
    end else if (load) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (next_q[i]) begin
          ent_sys_q[i]  <= sys_q;
          ent_page_q[i] <= vpage_q;
          ent_perm_q[i] <= mem_rd_data[9:7];
          ent_blk_q[i]  <= mem_rd_data[6:0];
        end
      end
    end
  end

  // R5
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> (ent_vld_q == '0));

  // R7
  rr_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(next_q) == 1);

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && sys_q && vpage_q == '0) |-> (!resp_trap && resp_paddr[15:9] == '0));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_trap |-> (resp_valid && resp_paddr == 16'd0));

  // R2
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_trap) |-> (resp_paddr[8:0] == off_q));
endmodule

// File: tb/addr_mapper_bench.sv
`timescale 1ns/1ps
module addr_mapper_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sys = 1'b0;
  logic [14:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic ptr_wr_en = 1'b0, ptr_wr_sel = 1'b0;
  logic [15:0] ptr_wr_data = '0;
  logic mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic req_ready, resp_valid, resp_trap, mem_rd_en;
  logic [15:0] resp_paddr, mem_rd_addr;

  int checks = 0, failures = 0;
  logic [15:0] m_ptr [2];
  logic m_vld [N];
  logic m_sys [N];
  logic [5:0] m_page [N];
  int m_next = 0;

  always #2 clk = ~clk;

  addr_mapper #(.NUM_ENT(N)) u_addr_mapper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_sys(req_sys), .req_kind(req_kind),
    .resp_valid(resp_valid), .resp_trap(resp_trap), .resp_paddr(resp_paddr),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));

  function automatic logic [15:0] tword(input logic [15:0] a);
    logic [15:0] b;
    b = a * 16'd7 + 16'd5;
    return {a[11:6] ^ 6'h2A, a[2:0] ^ a[5:3], b[6:0]};
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    mem_rd_data  <= tword(mem_rd_addr);
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ptr(input logic sel, input logic [15:0] val);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_sel = sel; ptr_wr_data = val;
    @(negedge clk);
    ptr_wr_en = 1'b0;
    m_ptr[sel] = val;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
  endtask

  task automatic do_req(input logic sys, input logic [5:0] page, input logic [8:0] off,
                        input logic [1:0] kind, input string tag);
    logic byp, hit, ok;
    logic [15:0] addr, w, exp_pa;
    int exp_reads, reads, cycles;
    byp = sys && page == 0;
    hit = 1'b0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_sys[i] == sys && m_page[i] == page) hit = 1'b1;
    exp_reads = (byp || hit) ? 0 : 1;
    if (exp_reads == 1) begin
      m_vld[m_next] = 1'b1; m_sys[m_next] = sys; m_page[m_next] = page;
      m_next = (m_next + 1) % N;
    end
    addr = m_ptr[sys] + {10'd0, page};
    w = tword(addr);
    case (kind)
      2'd0: ok = w[9];
      2'd1: ok = w[8];
      2'd2: ok = w[7];
      default: ok = 1'b0;
    endcase
    if (byp) ok = 1'b1;
    exp_pa = !ok ? 16'd0 : byp ? {7'd0, off} : {w[6:0], off};

    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_sys = sys; req_vaddr = {page, off}; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 1; reads = 0;
    while (!resp_valid && cycles < 40) begin
      if (mem_rd_en) begin
        reads++;
        check(mem_rd_addr == addr, "R5 read address", 32'(mem_rd_addr), 32'(addr));
      end
      check(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
      @(negedge clk);
      cycles++;
    end
    check(reads == exp_reads, tag, 32'(reads), 32'(exp_reads));
    check(cycles == (exp_reads == 1 ? 4 : 1), "R9 latency", 32'(cycles),
          32'(exp_reads == 1 ? 4 : 1));
    check(resp_trap == !ok, "R4 trap", 32'(resp_trap), 32'(!ok));
    check(resp_paddr == exp_pa, "R2 real address", 32'(resp_paddr), 32'(exp_pa));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_ptr[0] = '0; m_ptr[1] = '0;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 0);
    check(mem_rd_en == 1'b0, "R1 mem_rd_en", 32'(mem_rd_en), 0);
    do_req(1'b0, 6'd5, 9'h011, 2'd0, "R1 first request misses");

    set_ptr(1'b1, 16'h0100);
    set_ptr(1'b0, 16'h0200);
    // R2 R4 sweep over both privileges, all pages, all kinds
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 64; p++)
        for (int k = 0; k < 4; k++)
          do_req(s[0], p[5:0], 9'(p * 7 + k * 61), k[1:0], "R2/R4 sweep reads");

    // R3 privilege tag
    set_ptr(1'b0, 16'h0300);
    do_req(1'b0, 6'd9, 9'h1FF, 2'd0, "R3 user miss");
    do_req(1'b1, 6'd9, 9'h000, 2'd0, "R3 other privilege misses");
    do_req(1'b0, 6'd9, 9'h0AA, 2'd1, "R3 user hit");

    // R7 / R10 circular replacement and capacity
    set_ptr(1'b0, 16'h0400);
    for (int p = 1; p <= N; p++) do_req(1'b0, p[5:0], 9'd3, 2'd0, "R7 fill");
    for (int p = 1; p <= N; p++) do_req(1'b0, p[5:0], 9'd4, 2'd2, "R10 all resident");
    do_req(1'b0, 6'(N + 1), 9'd5, 2'd0, "R7 evict");
    do_req(1'b0, 6'd2, 9'd6, 2'd0, "R7 second still resident");
    do_req(1'b0, 6'd1, 9'd7, 2'd0, "R7 evicted page misses");
    do_req(1'b0, 6'd2, 9'd8, 2'd0, "R7 next victim misses");

    // R6 base write invalidates, R5 address wrap
    set_ptr(1'b0, 16'hFFF0);
    do_req(1'b0, 6'd3, 9'd9, 2'd0, "R6 invalidated");
    do_req(1'b0, 6'h20, 9'd10, 2'd1, "R5 wrapped address read");
    do_req(1'b0, 6'h20, 9'd11, 2'd2, "R5 refilled hit");

    // R8 system page 0 bypass
    for (int k = 0; k < 4; k++) begin
      do_req(1'b1, 6'd0, 9'(k * 100 + 17), k[1:0], "R8 no read");
      check(resp_trap == 1'b0, "R8 no trap", 32'(resp_trap), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule